// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block converts one high-level NAND request (page read, spare-only read, page program, block erase, identify, status) into the ordered stream of bus cycles that a raw NAND device expects. Each emitted cycle is tagged with its kind (command, address, data-in, data-out, identify, status), a byte value for command and address cycles, an internal page-buffer index and a spare-only select. A separate pin driver, outside this block, performs each cycle and acknowledges it with a one-cycle done pulse.

The number of column and page address cycles is chosen from the page mode and from the device size, given as log2 of its byte count. A large-page read or program moves four buffer quarters; a small-page one moves a single buffer. Each cycle is guarded by a timeout. On expiry the sequence is abandoned and a sticky error is raised. A completion flag is raised when the last cycle of a sequence is acknowledged, and it stays set until it is cleared.

Top module: `nand_cycle_seq`

## Requirements
- R1: When the column flag is set for a read, spare read, program or identify request, the command cycle is followed by column address cycles (kind 1) of value 0x00. There is one such cycle in small-page mode and two in large-page mode. Erase and status requests never carry column cycles.
- R2: Read, spare read, program and erase requests emit page address cycles (kind 1) in this order: page bits 7:0, then bits 15:8, then bits 23:16. The third cycle is emitted only for a high-density device.
- R3: A device counts as high-density when its log2 byte size is at least 28 in large-page mode, or at least 26 in small-page mode.
- R4: A read request (op 0) sends command 0x00 and its address cycles. In large-page mode this is followed by command 0x30 and then four data-out cycles (kind 3) to buffers 0, 1, 2 and 3, in that order. In small-page mode it is followed by one data-out cycle to buffer 0.
- R5: A spare read request (op 1) uses command 0x00 in large-page mode. In small-page mode it uses command 0x50 and its data-out cycle carries the spare select. The spare select is 0 on every other cycle.
- R6: A program request (op 2) sends command 0x80, the address cycles, data-in cycles (kind 2), and then command 0x10. The data-in cycles go to buffers 0 to 3 in large-page mode and to buffer 0 alone in small-page mode.
- R7: An erase request (op 3) sends command 0x60, the page cycles, and then command 0xD0.
- R8: An identify request (op 4) sends command 0x90, any column cycles, and one identify cycle (kind 4) to buffer 0. A status request (op 5) sends command 0x70 and one status cycle (kind 5) to buffer 1.
- R9: Each cycle holds its valid strobe and its fields unchanged until done is seen, and then the block moves to the next cycle.
- R10: If done is not seen within 2000 clocks of a cycle being presented, the sequence is aborted, busy falls, and the timeout error is set. It stays set until reset.
- R11: Busy rises on the clock after a request is accepted and falls after the last cycle is acknowledged. Requests presented while busy is high are ignored.
- R12: The completion flag is set when the last cycle is acknowledged and cleared by a pulse on the clear input. It is not set by an aborted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted when not busy |
| reqOp | input | 3 | 0 read, 1 spare read, 2 program, 3 erase, 4 identify, 5 status |
| reqColPresent | input | 1 | Request carries a column address |
| reqPage | input | 24 | Page address |
| largePage | input | 1 | 1 for large-page devices |
| devSizeLog2 | input | 6 | log2 of device size in bytes |
| busy | output | 1 | Sequence in progress |
| cycValid | output | 1 | A cycle is presented |
| cycKind | output | 3 | 0 cmd, 1 addr, 2 data-in, 3 data-out, 4 identify, 5 status |
| cycValue | output | 8 | Command or address byte |
| cycBuf | output | 2 | Internal buffer index |
| cycSpare | output | 1 | Spare-only transfer select |
| cycDone | input | 1 | Pin driver finished the presented cycle |
| doneFlag | output | 1 | Sequence completed |
| doneClr | input | 1 | Clears the completion flag |
| timeoutErr | output | 1 | Sticky timeout error |

## Verification
The assertions take for granted that the pin driver pulses done only while a cycle is presented. They also take for granted that the request fields matter only in the cycle a request is accepted. The bench's responder raises done only after it has seen the valid strobe, and it waits zero to two extra clocks first, so every stall length in the hold rule is exercised. Requests are driven for a single cycle, except for one request that is deliberately made while busy to test the ignore rule.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_SPARE = 3'd1, OP_PROG = 3'd2,
    OP_ERASE = 3'd3, OP_ID = 3'd4, OP_STATUS = 3'd5
  } seqOp_e;

  typedef enum logic [2:0] {
    K_CMD = 3'd0, K_ADDR = 3'd1, K_DIN = 3'd2,
    K_DOUT = 3'd3, K_ID = 3'd4, K_STAT = 3'd5
  } cycKind_e;

  // phase order is the order cycles appear on the bus
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0, PH_CMD = 3'd1, PH_COL = 3'd2, PH_PAGE = 3'd3,
    PH_CONF1 = 3'd4, PH_XFER = 3'd5, PH_CONF2 = 3'd6
  } phase_e;

  typedef struct packed {
    logic latch;
    logic idxClr;
    logic idxInc;
    logic tmoClr;
    logic tmoInc;
  } strobe_t;
endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int PAGE_W = 24,
  parameter int TIMEOUT_TICKS = 2000,
  parameter int LP_HD_LOG2 = 28,
  parameter int SP_HD_LOG2 = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  phase_e            phase,
  input  logic [2:0]        reqOp,
  input  logic              reqColPresent,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              largePage,
  input  logic [5:0]        devSizeLog2,
  output logic [6:1]        phaseEn,
  output logic              phaseLast,
  output logic              tmoHit,
  output logic [2:0]        cycKind,
  output logic [7:0]        cycValue,
  output logic [1:0]        cycBuf,
  output logic              cycSpare
);
  localparam int TMO_W = $clog2(TIMEOUT_TICKS);
  localparam int PAGE_BYTES = (PAGE_W + 7) / 8;
  localparam int IDX_W = 2;

  seqOp_e             opQ;
  logic               largeQ, colQ, hdQ;
  logic [PAGE_W-1:0]  pageQ;
  logic [IDX_W-1:0]   idx;
  logic [TMO_W-1:0]   tmoCnt;
  logic               hdNow;
  logic               isRead, moves4;
  logic [IDX_W-1:0]   colLast, pageLast, xferLast;
  logic [PAGE_BYTES*8-1:0] pageWide;

  assign hdNow = largePage ? (devSizeLog2 >= 6'(LP_HD_LOG2))
                           : (devSizeLog2 >= 6'(SP_HD_LOG2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ    <= OP_READ;
      largeQ <= 1'b0;
      colQ   <= 1'b0;
      hdQ    <= 1'b0;
      pageQ  <= '0;
    end else if (stb.latch) begin
      opQ    <= seqOp_e'(reqOp);
      largeQ <= largePage;
      colQ   <= reqColPresent;
      hdQ    <= hdNow;
      pageQ  <= reqPage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           idx <= '0;
    else if (stb.idxClr) idx <= '0;
    else if (stb.idxInc) idx <= idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           tmoCnt <= '0;
    else if (stb.tmoClr) tmoCnt <= '0;
    else if (stb.tmoInc) tmoCnt <= tmoCnt + 1'b1;
  end

  assign tmoHit = (tmoCnt == TMO_W'(TIMEOUT_TICKS - 1));

  assign isRead = (opQ == OP_READ) || (opQ == OP_SPARE);
  assign moves4 = largeQ && (isRead || opQ == OP_PROG);

  // which phases the latched request uses
  always_comb begin
    phaseEn[PH_CMD]   = 1'b1;
    phaseEn[PH_COL]   = colQ && (isRead || opQ == OP_PROG || opQ == OP_ID);
    phaseEn[PH_PAGE]  = isRead || opQ == OP_PROG || opQ == OP_ERASE;
    phaseEn[PH_CONF1] = isRead && largeQ;
    phaseEn[PH_XFER]  = (opQ != OP_ERASE);
    phaseEn[PH_CONF2] = (opQ == OP_PROG) || (opQ == OP_ERASE);
  end

  assign colLast  = largeQ ? 2'd1 : 2'd0;
  assign pageLast = hdQ ? 2'd2 : 2'd1;
  assign xferLast = moves4 ? 2'd3 : 2'd0;

  always_comb begin
    unique case (phase)
      PH_COL:  phaseLast = (idx == colLast);
      PH_PAGE: phaseLast = (idx == pageLast);
      PH_XFER: phaseLast = (idx == xferLast);
      default: phaseLast = 1'b1;
    endcase
  end

  assign pageWide = (PAGE_BYTES*8)'(pageQ);

  always_comb begin
    cycKind  = K_CMD;
    cycValue = 8'h00;
    cycBuf   = 2'd0;
    cycSpare = 1'b0;
    unique case (phase)
      PH_CMD: begin
        unique case (opQ)
          OP_SPARE:  cycValue = largeQ ? 8'h00 : 8'h50;
          OP_PROG:   cycValue = 8'h80;
          OP_ERASE:  cycValue = 8'h60;
          OP_ID:     cycValue = 8'h90;
          OP_STATUS: cycValue = 8'h70;
          default:   cycValue = 8'h00;
        endcase
      end
      PH_COL:   cycKind = K_ADDR;
      PH_PAGE: begin
        cycKind  = K_ADDR;
        cycValue = pageWide[8*idx +: 8];
      end
      PH_CONF1: cycValue = 8'h30;
      PH_XFER: begin
        unique case (opQ)
          OP_PROG:   cycKind = K_DIN;
          OP_ID:     cycKind = K_ID;
          OP_STATUS: cycKind = K_STAT;
          default:   cycKind = K_DOUT;
        endcase
        cycBuf   = (opQ == OP_STATUS) ? 2'd1 : idx;
        cycSpare = (opQ == OP_SPARE) && !largeQ;
      end
      PH_CONF2: cycValue = (opQ == OP_PROG) ? 8'h10 : 8'hD0;
      default: ;
    endcase
  end
endmodule

// File: rtl/nand_seq_ctl.sv
module nand_seq_ctl
  import nand_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cycDone,
  input  logic       doneClr,
  input  logic [6:1] phaseEn,
  input  logic       phaseLast,
  input  logic       tmoHit,
  output phase_e     phase,
  output strobe_t    stb,
  output logic       doneFlag,
  output logic       timeoutErr
);
  phase_e phaseNext, follow;
  logic   found, setDone, setErr;

  // first enabled phase after the current one
  always_comb begin
    follow = PH_IDLE;
    found  = 1'b0;
    for (int p = 1; p < 7; p++) begin
      if (!found && p > int'(phase) && phaseEn[p]) begin
        follow = phase_e'(3'(p));
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    phaseNext = phase;
    stb       = '0;
    setDone   = 1'b0;
    setErr    = 1'b0;
    if (phase == PH_IDLE) begin
      if (reqValid) begin
        phaseNext  = PH_CMD;
        stb.latch  = 1'b1;
        stb.idxClr = 1'b1;
        stb.tmoClr = 1'b1;
      end
    end else if (cycDone) begin
      stb.tmoClr = 1'b1;
      if (phaseLast) begin
        phaseNext  = follow;
        stb.idxClr = 1'b1;
        setDone    = (follow == PH_IDLE);
      end else begin
        stb.idxInc = 1'b1;
      end
    end else if (tmoHit) begin
      phaseNext = PH_IDLE;
      setErr    = 1'b1;
    end else begin
      stb.tmoInc = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      doneFlag   <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (setDone)      doneFlag <= 1'b1;
      else if (doneClr) doneFlag <= 1'b0;
      if (setErr)       timeoutErr <= 1'b1;
    end
  end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_W = 24,
  parameter int TIMEOUT_TICKS = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic              reqColPresent,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              largePage,
  input  logic [5:0]        devSizeLog2,
  output logic              busy,
  output logic              cycValid,
  output logic [2:0]        cycKind,
  output logic [7:0]        cycValue,
  output logic [1:0]        cycBuf,
  output logic              cycSpare,
  input  logic              cycDone,
  output logic              doneFlag,
  input  logic              doneClr,
  output logic              timeoutErr
);
  phase_e     phase;
  strobe_t    stb;
  logic [6:1] phaseEn;
  logic       phaseLast, tmoHit;

  nand_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cycDone(cycDone),
    .doneClr(doneClr), .phaseEn(phaseEn), .phaseLast(phaseLast),
    .tmoHit(tmoHit), .phase(phase), .stb(stb), .doneFlag(doneFlag),
    .timeoutErr(timeoutErr)
  );

  nand_seq_dp #(.PAGE_W(PAGE_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .phase(phase), .reqOp(reqOp),
    .reqColPresent(reqColPresent), .reqPage(reqPage), .largePage(largePage),
    .devSizeLog2(devSizeLog2), .phaseEn(phaseEn), .phaseLast(phaseLast),
    .tmoHit(tmoHit), .cycKind(cycKind), .cycValue(cycValue),
    .cycBuf(cycBuf), .cycSpare(cycSpare)
  );

  assign busy     = (phase != PH_IDLE);
  assign cycValid = busy;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       busy,
  input logic       cycValid,
  input logic       cycDone,
  input logic [2:0] cycKind,
  input logic [7:0] cycValue,
  input logic [1:0] cycBuf,
  input logic       cycSpare,
  input logic       doneFlag,
  input logic       timeoutErr
);
  // R9: an unacknowledged cycle stays presented with identical fields
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !cycDone && !timeoutErr) |=> (cycValid || timeoutErr));
  p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !cycDone) ##1 cycValid |->
      ($stable(cycKind) && $stable(cycValue) && $stable(cycBuf) && $stable(cycSpare)));
  // R11: a request taken while idle makes busy rise next cycle
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);
  // R10: the timeout error never clears
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> timeoutErr);
  // R8: status transfers land in buffer 1 without spare select
  p_status_buf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycKind == 3'd5) |-> (cycBuf == 2'd1 && !cycSpare));
  // R5: spare select only accompanies data-out cycles
  p_spare_dout_r5: assert property (@(posedge clk) disable iff (!rstN)
    cycSpare |-> (cycKind == 3'd3));
  // R12: completion is only raised at the end of a busy sequence
  p_done_after_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ($past(busy) && !busy));
endmodule

bind nand_cycle_seq nand_seq_chk u_chk (.*);

// File: tb/nand_cycle_seq_tb.sv
module nand_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic        reqColPresent = 1'b0;
  logic [23:0] reqPage = 24'd0;
  logic        largePage = 1'b0;
  logic [5:0]  devSizeLog2 = 6'd20;
  logic        cycDone = 1'b0;
  logic        doneClr = 1'b0;
  logic        busy, cycValid, cycSpare, doneFlag, timeoutErr;
  logic [2:0]  cycKind;
  logic [7:0]  cycValue;
  logic [1:0]  cycBuf;

  int checks = 0;
  int fails  = 0;

  int expKind[16];
  int expVal[16];
  int expBuf[16];
  int expSp[16];
  int expN;

  always #2.5 clk = ~clk;

  nand_cycle_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqColPresent(reqColPresent), .reqPage(reqPage), .largePage(largePage),
    .devSizeLog2(devSizeLog2), .busy(busy), .cycValid(cycValid),
    .cycKind(cycKind), .cycValue(cycValue), .cycBuf(cycBuf),
    .cycSpare(cycSpare), .cycDone(cycDone), .doneFlag(doneFlag),
    .doneClr(doneClr), .timeoutErr(timeoutErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int k, input int v, input int b, input int s);
    expKind[expN] = k; expVal[expN] = v; expBuf[expN] = b; expSp[expN] = s;
    expN++;
  endtask

  // expected cycle list from the requirements
  task automatic build(input int op, input bit lg, input bit col, input int sz, input logic [23:0] pg);
    bit hd, rd;
    int nx;
    expN = 0;
    hd = lg ? (sz >= 28) : (sz >= 26);                       // R3
    rd = (op == 0) || (op == 1);
    case (op)                                               // R4 R5 R6 R7 R8
      0: push(0, 8'h00, 0, 0);
      1: push(0, lg ? 8'h00 : 8'h50, 0, 0);
      2: push(0, 8'h80, 0, 0);
      3: push(0, 8'h60, 0, 0);
      4: push(0, 8'h90, 0, 0);
      default: push(0, 8'h70, 0, 0);
    endcase
    if (col && op != 3 && op != 5) begin                    // R1
      push(1, 0, 0, 0);
      if (lg) push(1, 0, 0, 0);
    end
    if (op <= 3) begin                                      // R2
      push(1, pg[7:0], 0, 0);
      push(1, pg[15:8], 0, 0);
      if (hd) push(1, pg[23:16], 0, 0);
    end
    if (rd && lg) push(0, 8'h30, 0, 0);
    nx = (lg && (rd || op == 2)) ? 4 : 1;
    if (op == 4) push(4, 0, 0, 0);
    else if (op == 5) push(5, 0, 1, 0);
    else if (op != 3)
      for (int i = 0; i < nx; i++)
        push(op == 2 ? 2 : 3, 0, i, (op == 1 && !lg) ? 1 : 0);
    if (op == 2) push(0, 8'h10, 0, 0);
    if (op == 3) push(0, 8'hD0, 0, 0);
  endtask

  task automatic runSeq(input int op, input bit lg, input bit col, input int sz,
                        input logic [23:0] pg, input bit pokeBusy);
    int k;
    build(op, lg, col, sz, pg);
    @(negedge clk);
    reqOp = 3'(op); largePage = lg; reqColPresent = col;
    devSizeLog2 = 6'(sz); reqPage = pg; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
    k = 0;
    while (busy && k < 16) begin
      if (pokeBusy && k == 1) begin
        reqOp = 3'd5; reqPage = ~pg; largePage = ~lg; reqValid = 1'b1;
      end
      for (int d = 0; d < k % 3; d++) begin
        @(negedge clk);
        reqValid = 1'b0;
        chk(cycValid == 1'b1, "R9 valid held", int'(cycValid), 1);
      end
      if (k < expN) begin
        chk(int'(cycKind) == expKind[k], "R1-R8 kind", int'(cycKind), expKind[k]);
        chk(int'(cycValue) == expVal[k], "R1 R2 value", int'(cycValue), expVal[k]);
        chk(int'(cycBuf) == expBuf[k], "R4 R6 R8 buffer", int'(cycBuf), expBuf[k]);
        chk(int'(cycSpare) == expSp[k], "R5 spare", int'(cycSpare), expSp[k]);
      end
      cycDone = 1'b1;
      @(negedge clk);
      cycDone = 1'b0;
      reqValid = 1'b0;
      k++;
    end
    chk(k == expN, "R9 cycle count", k, expN);
    chk(busy == 1'b0, "R11 busy falls", int'(busy), 0);
    chk(doneFlag == 1'b1, "R12 done set", int'(doneFlag), 1);
    @(negedge clk);
    chk(cycValid == 1'b0, "R11 ignored request", int'(cycValid), 0);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    chk(doneFlag == 1'b0, "R12 done cleared", int'(doneFlag), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && cycValid == 1'b0, "R11 reset idle", int'(busy), 0);
    chk(doneFlag == 1'b0 && timeoutErr == 1'b0, "R12 R10 reset flags",
        int'(doneFlag), 0);
    rstN = 1'b1;
    // sweep of opcodes, page mode, column flag and densities
    for (int op = 0; op < 6; op++)
      for (int lg = 0; lg < 2; lg++)
        for (int col = 0; col < 2; col++)
          for (int sz = 25; sz < 29; sz++)
            runSeq(op, lg[0], col[0], sz,
                   {8'(op*37 + sz), 8'(lg*90 + col*11 + 3), 8'(sz*5 + op)}, 1'b0);
    // R11: a request while busy is ignored
    runSeq(0, 1'b1, 1'b1, 28, 24'hC3A55A, 1'b1);
    // R10: no acknowledge leads to abort
    @(negedge clk);
    reqOp = 3'd0; largePage = 1'b0; reqColPresent = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (1990) @(negedge clk);
    chk(busy == 1'b1 && timeoutErr == 1'b0, "R10 still waiting", int'(busy), 1);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R10 aborted", int'(busy), 0);
    chk(timeoutErr == 1'b1, "R10 error set", int'(timeoutErr), 1);
    chk(doneFlag == 1'b0, "R12 no done on abort", int'(doneFlag), 0);
    runSeq(5, 1'b0, 1'b0, 20, 24'h0, 1'b0);
    chk(timeoutErr == 1'b1, "R10 error sticky", int'(timeoutErr), 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule